// File: doc/BRIEF.md
# Peripheral Interrupt Detect Block

This block watches eight interrupt source lines that belong to one peripheral and turns them into a single interrupt request. Every line is first brought into the local clock domain by a flop synchronizer. Each line is then judged by its own small detector. That detector works either on edges or on levels. In edge mode it can fire on a rising edge, a falling edge or both. In level mode it can treat the line as active-high or active-low. A detected event sets a pending bit for that line. The request output is raised while any pending line also has its enable bit set.

Software reaches the block through a byte-wide register port. The port has a write strobe, a read strobe, an 8-bit offset, write data and read data. Read data is combinational: it is valid in the same cycle as the read strobe. Bit n of every register belongs to line n.

The register offsets are:
- 0x10: live line state, read only.
- 0x11: detection kind, read and write.
- 0x12: high/rising select, read and write.
- 0x13: low/falling select, read and write.
- 0x14: pending clear, write only.
- 0x15: enable set.
- 0x16: enable clear.
- 0x18: pending state, read only.

Enables and pending bits are changed only by write-one masks. A mask bit of 0 leaves the matching bit alone.

Top module: `pirq_detect`

## Requirements
- R1: After reset every readable offset from 0x10 to 0x18 returns 0 while the lines are low, and irq_out is low.
- R2: Offset 0x10 returns the synchronized line state. After an input change this read still returns the old value one clock later and returns the new value two clocks later. Reading it latches nothing.
- R3: Offsets 0x11 (kind), 0x12 (high/rising) and 0x13 (low/falling) are read and write registers. Three writes on back-to-back cycles at 0x11, 0x12 and 0x13 leave each register holding its own byte.
- R4: When a line's kind bit is 1 (edge mode), a 0-to-1 change sets its pending bit if its 0x12 bit is 1. A 1-to-0 change sets it if its 0x13 bit is 1. With both bits set, either change sets it.
- R5: When a line's kind bit is 0 (level mode), the pending bit is set while the line is high if only the 0x12 bit is 1, and while the line is low if only the 0x13 bit is 1. If both bits are 1, or neither is, the line never sets its pending bit.
- R6: A write to 0x15 sets the enable bits where the data has ones. A write to 0x16 clears the enable bits where the data has ones. Bits written as 0 keep their value. A read at either 0x15 or 0x16 returns the enables.
- R7: A write to 0x14 clears the pending bits where the data has ones, effective at the clock that takes the write. Offset 0x18 returns the pending bits.
- R8: A level-mode line whose level is still active reads 0 in its pending bit in the cycle right after the clear is taken. It reads 1 again one clock later.
- R9: An edge event that reaches the pending logic at the same clock as a clear write for that line leaves the pending bit set.
- R10: Pending bits are set whether or not the line is enabled. irq_out is high exactly when some line has both its pending bit and its enable bit set.
- R11: Reads at unmapped offsets and at the write-only offset 0x14 return 0. Writes to unmapped offsets and to the read-only offsets 0x10 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lines | input | 8 | Raw interrupt source lines, bit n is line n |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of rd_en, 0 otherwise |
| irq_out | output | 1 | Interrupt request, OR over lines of pending AND enable |

## Verification
The two functions that can fall in the same cycle are a newly detected event on a line and a software clear of that same line's pending bit. The bench provokes this by counting register stages. It changes an edge-mode input, waits the two synchronizer clocks, and issues the clear so that the write is taken on the very clock at which the edge arrives. The pending bit must read 1 afterwards. A clear issued one clock later must read 0. A level-mode line is judged the other way round: it must read 0 in the cycle right after the clear and 1 one clock after that.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam logic [7:0] OFF_LIVE   = 8'h10;
   localparam logic [7:0] OFF_KIND   = 8'h11;
   localparam logic [7:0] OFF_RISE   = 8'h12;
   localparam logic [7:0] OFF_FALL   = 8'h13;
   localparam logic [7:0] OFF_ACKCLR = 8'h14;
   localparam logic [7:0] OFF_ENSET  = 8'h15;
   localparam logic [7:0] OFF_ENCLR  = 8'h16;
   localparam logic [7:0] OFF_PEND   = 8'h18;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LIVE,
      SEL_KIND,
      SEL_RISE,
      SEL_FALL,
      SEL_EN,
      SEL_PEND
   } rd_sel_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("pirq_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flop_q <= '0;
         else        flop_q <= d;
      end
      assign q = flop_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end
endmodule

// File: rtl/pirq_cell.sv
module pirq_cell (
   input  logic cur,
   input  logic prev,
   input  logic kind,
   input  logic rise,
   input  logic fall,
   output logic edge_hit,
   output logic lvl_hit
);
   logic went_up;
   logic went_down;
   logic lvl_sel_ok;
   logic lvl_active;

   assign went_up    = cur & ~prev;
   assign went_down  = ~cur & prev;
   assign lvl_sel_ok = rise ^ fall;
   assign lvl_active = rise ? cur : ~cur;

   assign edge_hit = kind & ((rise & went_up) | (fall & went_down));
   assign lvl_hit  = ~kind & lvl_sel_ok & lvl_active;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int LINES = 8,
   parameter int AW    = 8,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic [LINES-1:0] live,
   input  logic [LINES-1:0] edge_hit,
   input  logic [LINES-1:0] lvl_hit,
   output logic [DW-1:0]    rdata,
   output logic [LINES-1:0] kind_q,
   output logic [LINES-1:0] rise_q,
   output logic [LINES-1:0] fall_q,
   output logic [LINES-1:0] en_q,
   output logic [LINES-1:0] pend_q
);
   logic [LINES-1:0] mask;
   logic             hit_kind, hit_rise, hit_fall;
   logic             hit_ack, hit_enset, hit_enclr;
   logic [LINES-1:0] clr_mask;
   logic [LINES-1:0] pend_d;
   rd_sel_e          sel;
   logic [LINES-1:0] rd_val;

   assign mask = wdata[LINES-1:0];

   assign hit_kind  = wr_en && (addr == AW'(OFF_KIND));
   assign hit_rise  = wr_en && (addr == AW'(OFF_RISE));
   assign hit_fall  = wr_en && (addr == AW'(OFF_FALL));
   assign hit_ack   = wr_en && (addr == AW'(OFF_ACKCLR));
   assign hit_enset = wr_en && (addr == AW'(OFF_ENSET));
   assign hit_enclr = wr_en && (addr == AW'(OFF_ENCLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         if (hit_kind) kind_q <= mask;
         if (hit_rise) rise_q <= mask;
         if (hit_fall) fall_q <= mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (hit_enset) en_q <= en_q | mask;
      else if (hit_enclr) en_q <= en_q & ~mask;
   end

   // Edge events outrank a clear; level events yield to it and return next cycle.
   assign clr_mask = hit_ack ? mask : '0;
   assign pend_d   = (pend_q & ~clr_mask) | edge_hit | (lvl_hit & ~clr_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   always_comb begin
      sel = SEL_NONE;
      if (rd_en) begin
         if (addr == AW'(OFF_LIVE))       sel = SEL_LIVE;
         else if (addr == AW'(OFF_KIND))  sel = SEL_KIND;
         else if (addr == AW'(OFF_RISE))  sel = SEL_RISE;
         else if (addr == AW'(OFF_FALL))  sel = SEL_FALL;
         else if (addr == AW'(OFF_ENSET)) sel = SEL_EN;
         else if (addr == AW'(OFF_ENCLR)) sel = SEL_EN;
         else if (addr == AW'(OFF_PEND))  sel = SEL_PEND;
      end
   end

   always_comb begin
      case (sel)
         SEL_LIVE: rd_val = live;
         SEL_KIND: rd_val = kind_q;
         SEL_RISE: rd_val = rise_q;
         SEL_FALL: rd_val = fall_q;
         SEL_EN:   rd_val = en_q;
         SEL_PEND: rd_val = pend_q;
         default:  rd_val = '0;
      endcase
      rdata = '0;
      rdata[LINES-1:0] = rd_val;
   end
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect #(
   parameter int LINES       = 8,
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] in_lines,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             irq_out
);
   if (LINES < 1 || LINES > DW) begin : g_bad_lines
      $error("pirq_detect: LINES must lie in 1..DW");
   end
   if (AW < 5) begin : g_bad_aw
      $error("pirq_detect: AW too narrow for the register offsets");
   end

   logic [LINES-1:0] live_q;
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] edge_hit;
   logic [LINES-1:0] lvl_hit;
   logic [LINES-1:0] kind_q, rise_q, fall_q, en_q, pend_q;

   pirq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_lines),
      .q     (live_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= live_q;
   end

   for (genvar n = 0; n < LINES; n++) begin : g_line
      pirq_cell u_cell (
         .cur      (live_q[n]),
         .prev     (prev_q[n]),
         .kind     (kind_q[n]),
         .rise     (rise_q[n]),
         .fall     (fall_q[n]),
         .edge_hit (edge_hit[n]),
         .lvl_hit  (lvl_hit[n])
      );
   end

   pirq_regs #(.LINES(LINES), .AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .live     (live_q),
      .edge_hit (edge_hit),
      .lvl_hit  (lvl_hit),
      .rdata    (rdata),
      .kind_q   (kind_q),
      .rise_q   (rise_q),
      .fall_q   (fall_q),
      .en_q     (en_q),
      .pend_q   (pend_q)
   );

   assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/pirq_detect_chk.sv
module pirq_detect_chk
   import pirq_pkg::*;
#(
   parameter int LINES = 8,
   parameter int AW    = 8,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [AW-1:0]    addr,
   input logic [DW-1:0]    wdata,
   input logic [DW-1:0]    rdata,
   input logic             irq_out,
   input logic [LINES-1:0] live,
   input logic [LINES-1:0] en,
   input logic [LINES-1:0] pend,
   input logic [LINES-1:0] edge_hit
);
   logic unmapped;
   assign unmapped = !(addr == AW'(OFF_LIVE)  || addr == AW'(OFF_KIND) ||
                       addr == AW'(OFF_RISE)  || addr == AW'(OFF_FALL) ||
                       addr == AW'(OFF_ENSET) || addr == AW'(OFF_ENCLR) ||
                       addr == AW'(OFF_PEND));

   // R6
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_ENSET)) |=>
         ((en & $past(wdata[LINES-1:0])) == $past(wdata[LINES-1:0])));

   // R6
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_ENCLR)) |=> ((en & $past(wdata[LINES-1:0])) == '0));

   // R7
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_ACKCLR)) |=>
         ((pend & $past(wdata[LINES-1:0]) & ~$past(edge_hit)) == '0));

   // R7
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~pend) != '0) |-> $past(wr_en && addr == AW'(OFF_ACKCLR)));

   // R9
   edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_out);

   // R2
   live_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(OFF_LIVE)) |-> (rdata[LINES-1:0] == live));

   // R11
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && unmapped) |-> (rdata == '0));
endmodule

bind pirq_detect pirq_detect_chk #(.LINES(LINES), .AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .irq_out  (irq_out),
   .live     (live_q),
   .en       (en_q),
   .pend     (pend_q),
   .edge_hit (edge_hit)
);

// File: tb/pirq_detect_bench.sv
`timescale 1ns/1ps
module pirq_detect_bench;
   import pirq_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] in_lines = 8'h00;
   logic [7:0] rdata;
   logic       irq_out;

   always #2 clk = ~clk;

   pirq_detect u_pirq_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_lines (in_lines),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .irq_out  (irq_out)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      rd_en = 1'b1; addr = a;
      #0.2;
      v = rdata;
      rd_en = 1'b0; addr = 8'h00;
   endtask

   task automatic drive(input logic [7:0] v);
      @(negedge clk);
      in_lines = v;
   endtask

   function automatic logic [7:0] m_edge(logic [7:0] k, logic [7:0] h, logic [7:0] l,
                                         logic [7:0] p, logic [7:0] c);
      return k & ((h & c & ~p) | (l & ~c & p));
   endfunction

   function automatic logic [7:0] m_lvl(logic [7:0] k, logic [7:0] h, logic [7:0] l,
                                        logic [7:0] c);
      return ~k & ((h & ~l & c) | (l & ~h & ~c));
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] pend;
      logic [7:0] k, h, l, env;
      logic [7:0] prev;
      logic [7:0] pats [6];
      pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hFF;
      pats[3] = 8'h00; pats[4] = 8'h3C; pats[5] = 8'hC3;
      k = 8'h00; h = 8'h00; l = 8'h00; env = 8'h00; pend = 8'h00;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1: reset state on every offset in the window
      for (int a = 8'h10; a <= 8'h18; a++) begin
         rd(8'(a), v);
         chk($sformatf("R1 offset %h", a), v, 8'h00);
      end
      chk("R1 irq", {7'b0, irq_out}, 8'h00);

      // R2: synchronizer latency; R5: no polarity selected means nothing latches
      drive(8'h81);
      step();
      rd(OFF_LIVE, v); chk("R2 live one clock", v, 8'h00);
      step();
      rd(OFF_LIVE, v); chk("R2 live two clocks", v, 8'h81);
      repeat (3) step();
      rd(OFF_PEND, v); chk("R5 neither bit", v, 8'h00);
      drive(8'h00);
      repeat (4) step();

      // Sweep: each line sees all eight kind/high/low combinations across cfg
      for (int cfg = 0; cfg < 8; cfg++) begin
         k = {8{cfg[2]}} ^ 8'h33;
         h = {8{cfg[1]}} ^ 8'h55;
         l = {8{cfg[0]}} ^ 8'h0F;
         env = 8'(cfg * 8'h25 + 8'h11);
         drive(8'h00);
         repeat (4) step();
         wr(OFF_KIND, k);
         wr(OFF_RISE, h);
         wr(OFF_FALL, l);
         rd(OFF_KIND, v); chk("R3 kind", v, k);
         rd(OFF_RISE, v); chk("R3 rise", v, h);
         rd(OFF_FALL, v); chk("R3 fall", v, l);
         wr(OFF_ENCLR, 8'hFF);
         wr(OFF_ENSET, env);
         rd(OFF_ENSET, v); chk("R6 en at set offset", v, env);
         rd(OFF_ENCLR, v); chk("R6 en at clear offset", v, env);
         wr(OFF_ACKCLR, 8'hFF);
         repeat (2) step();
         pend = m_lvl(k, h, l, 8'h00);
         prev = 8'h00;
         for (int p = 0; p < 6; p++) begin
            drive(pats[p]);
            repeat (4) step();
            pend = pend | m_edge(k, h, l, prev, pats[p]) | m_lvl(k, h, l, pats[p]);
            rd(OFF_PEND, v); chk($sformatf("R4 R5 pend cfg%0d pat%0d", cfg, p), v, pend);
            rd(OFF_LIVE, v); chk("R2 live", v, pats[p]);
            chk("R10 irq", {7'b0, irq_out}, {7'b0, |(pend & env)});
            prev = pats[p];
         end
         wr(OFF_ACKCLR, 8'hAA);
         pend = pend & ~8'hAA;
         rd(OFF_PEND, v); chk("R7 partial clear", v, pend);
         step();
         pend = pend | m_lvl(k, h, l, prev);
         rd(OFF_PEND, v); chk("R8 level returns", v, pend);
      end

      // R6: zero mask bits keep their enables
      wr(OFF_ENCLR, 8'hFF);
      wr(OFF_ENSET, 8'h3C);
      wr(OFF_ENSET, 8'h01);
      rd(OFF_ENSET, v); chk("R6 set keeps others", v, 8'h3D);
      wr(OFF_ENCLR, 8'h20);
      rd(OFF_ENCLR, v); chk("R6 clear keeps others", v, 8'h1D);

      // R8: single active-high level line, clear then reassert
      drive(8'h00);
      repeat (4) step();
      wr(OFF_KIND, 8'h00);
      wr(OFF_RISE, 8'h02);
      wr(OFF_FALL, 8'h00);
      drive(8'h02);
      repeat (4) step();
      wr(OFF_ACKCLR, 8'hFF);
      rd(OFF_PEND, v); chk("R8 cleared cycle", v, 8'h00);
      step();
      rd(OFF_PEND, v); chk("R8 reasserted", v, 8'h02);
      chk("R10 enabled level irq", {7'b0, irq_out}, 8'h00);

      // R9: edge arrives on the clock that takes the clear
      drive(8'h00);
      wr(OFF_KIND, 8'hFF);
      wr(OFF_RISE, 8'h01);
      wr(OFF_FALL, 8'h00);
      repeat (4) step();
      wr(OFF_ACKCLR, 8'hFF);
      rd(OFF_PEND, v); chk("R9 pre clear", v, 8'h00);
      drive(8'h01);
      step();
      step();
      wr(OFF_ACKCLR, 8'h01);
      rd(OFF_PEND, v); chk("R9 edge wins clear", v, 8'h01);
      chk("R10 irq enabled line0", {7'b0, irq_out}, 8'h01);
      wr(OFF_ACKCLR, 8'h01);
      rd(OFF_PEND, v); chk("R7 later clear", v, 8'h00);
      drive(8'h00);
      step();
      step();
      step();
      rd(OFF_PEND, v); chk("R4 no falling select", v, 8'h00);

      // R11: ignored writes and zero reads
      wr(OFF_ENSET, 8'h80);
      drive(8'h01);
      repeat (4) step();
      wr(8'h17, 8'hFF);
      wr(8'h00, 8'hFF);
      wr(OFF_LIVE, 8'hFF);
      wr(OFF_PEND, 8'h00);
      wr(8'hFF, 8'hFF);
      rd(OFF_KIND, v); chk("R11 kind kept", v, 8'hFF);
      rd(OFF_RISE, v); chk("R11 rise kept", v, 8'h01);
      rd(OFF_FALL, v); chk("R11 fall kept", v, 8'h00);
      rd(OFF_ENSET, v); chk("R11 en kept", v, 8'h9D);
      rd(OFF_PEND, v); chk("R11 pend kept", v, 8'h01);
      rd(OFF_LIVE, v); chk("R11 live kept", v, 8'h01);
      rd(8'h17, v); chk("R11 read 17", v, 8'h00);
      rd(8'h19, v); chk("R11 read 19", v, 8'h00);
      rd(8'h00, v); chk("R11 read 00", v, 8'h00);
      rd(OFF_ACKCLR, v); chk("R11 read clear offset", v, 8'h00);
      rd(8'hFF, v); chk("R11 read ff", v, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule